// File: doc/BRIEF.md
# VLIW Execute Packet Dispatcher

This block sits between a four-stage instruction fetch pipeline and the decode stage of a wide-issue processor. Fetch delivers fixed-size fetch packets of eight 32-bit instruction words. Bit 0 of every word is a chaining flag. A value of 1 says the next slot issues in the same cycle as this one. A value of 0 closes the current issue group. The dispatcher carves each fetch packet into one or more such groups, called execute packets, and hands exactly one group per cycle to decode.

A fetch packet that holds k execute packets stays in dispatch for k consecutive cycles. During all but the last of those cycles the dispatcher raises a stall to fetch. The stall freezes every fetch packet still in address generation, address send, wait and receive, and it keeps a new fetch from starting. The stall is combinational from the dispatch register, so it drops in the same cycle that the final group of the packet goes to decode. Issued words keep their slot position, and a per-slot valid vector marks which slots belong to the current group.

Top module: `vliw_ep_dispatch`

## Requirements
- R1: During and after a synchronous active-high reset, with no packet accepted yet, all slot valids are 0, the stall output is 0 and the fetch ready output is 1.
- R2: While dispatch holds no packet, fetch ready is 1, and a packet offered with valid high is taken at that edge and its first group is presented in the following cycle.
- R3: An execute packet starts at the first slot not yet issued and ends at the first slot, at or above it, whose bit 0 is 0; exactly the slots in that range have their valid bit set in that cycle.
- R4: Bit 0 of slot 7 is ignored: slot 7 always closes the group it belongs to.
- R5: A valid slot carries the word from the same slot index of the fetch packet; slots that are not valid carry all zeros.
- R6: A fetch packet with k execute packets (k equal to one plus the number of zeros among bits 0 of slots 0 to 6) issues one group per cycle over k consecutive cycles.
- R7: The stall output is 1 exactly in the cycles in which at least one further group of the held packet remains after the one being issued, so a three-group packet stalls for two cycles.
- R8: Fetch ready is the inverse of the stall output; no new packet enters dispatch while the stall is 1.
- R9: A packet whose bits 0 in slots 0 to 6 are all 1 issues all eight slots in one cycle and causes no stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fp_valid | input | 1 | Fetch offers a fetch packet |
| fp_data | input | 256 | Eight instruction words, slot i in bits 32*i+31 to 32*i |
| fp_ready | output | 1 | Dispatch takes the offered packet at this edge |
| fetch_stall | output | 1 | Freeze the fetch pipeline |
| slot_valid | output | 8 | Per-slot valid of the group issued this cycle |
| slot_data | output | 256 | Issued words at their original slot positions |

## Verification
The bench sends every combination of chaining flags on slots 0 to 6, with slot 7's flag varied, so each group length and start position occurs. A dispatcher that reads slot 7's flag would merge groups into the next packet or hang. A scanner that is off by one would show valid masks that are shifted or one slot wide. A stall that is registered, not combinational, would last one cycle too long and swallow a fetch packet. The bench also replays a three-group packet followed by six fully parallel packets, and it inserts idle input cycles and offers packets during stalls. It counts stall cycles per packet and checks that no packet slips in while the stall is high.

// File: rtl/vliw_disp_pkg.sv
package vliw_disp_pkg;
    parameter int unsigned NSLOT   = 8;
    parameter int unsigned WORD_W  = 32;
    parameter int unsigned CHAIN_B = 0;
    localparam int unsigned IDX_W  = $clog2(NSLOT);
    localparam int unsigned PKT_W  = NSLOT * WORD_W;

    typedef struct packed {
        logic               held;
        logic [IDX_W-1:0]   start;
        logic [PKT_W-1:0]   words;
    } disp_state_t;
endpackage

// File: rtl/ep_end_finder.sv
module ep_end_finder #(
    parameter int unsigned N     = 8,
    parameter int unsigned IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     chain,
    input  logic [IDX_W-1:0] start,
    output logic [IDX_W-1:0] last
);
    logic found;

    always_comb begin
        last  = IDX_W'(N - 1);
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!found && (IDX_W'(i) >= start) && !chain[i]) begin
                last  = IDX_W'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ep_slot_mask.sv
module ep_slot_mask #(
    parameter int unsigned N     = 8,
    parameter int unsigned IDX_W = $clog2(N)
) (
    input  logic             enable,
    input  logic [IDX_W-1:0] start,
    input  logic [IDX_W-1:0] last,
    output logic [N-1:0]     mask
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign mask[i] = enable && (IDX_W'(i) >= start) && (IDX_W'(i) <= last);
    end
endmodule

// File: rtl/vliw_ep_dispatch.sv
module vliw_ep_dispatch
    import vliw_disp_pkg::*;
#(
    parameter int unsigned N = NSLOT,
    parameter int unsigned W = WORD_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           fp_valid,
    input  logic [N*W-1:0] fp_data,
    output logic           fp_ready,
    output logic           fetch_stall,
    output logic [N-1:0]   slot_valid,
    output logic [N*W-1:0] slot_data
);
    disp_state_t state_d, state_q;

    logic [N-1:0]     chain;
    logic [IDX_W-1:0] last_idx;
    logic [N-1:0]     group_mask;
    logic             is_final;

    // Chaining flag per slot; the top slot always terminates its group.
    for (genvar i = 0; i < N; i++) begin : g_chain
        if (i == N - 1) begin : g_top
            assign chain[i] = 1'b0;
        end else begin : g_low
            assign chain[i] = state_q.words[i*W + CHAIN_B];
        end
    end

    ep_end_finder #(.N(N), .IDX_W(IDX_W)) u_end (
        .chain (chain),
        .start (state_q.start),
        .last  (last_idx)
    );

    ep_slot_mask #(.N(N), .IDX_W(IDX_W)) u_mask (
        .enable (state_q.held),
        .start  (state_q.start),
        .last   (last_idx),
        .mask   (group_mask)
    );

    assign is_final    = (last_idx == IDX_W'(N - 1));
    assign fetch_stall = state_q.held && !is_final;
    assign fp_ready    = !fetch_stall;
    assign slot_valid  = group_mask;

    for (genvar i = 0; i < N; i++) begin : g_out
        assign slot_data[i*W +: W] = group_mask[i] ? state_q.words[i*W +: W] : '0;
    end

    always_comb begin
        state_d = state_q;
        if (state_q.held) begin
            if (is_final) begin
                state_d.held = 1'b0;
            end else begin
                state_d.start = last_idx + 1'b1;
            end
        end
        if (fp_valid && fp_ready) begin
            state_d.held  = 1'b1;
            state_d.start = '0;
            state_d.words = fp_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/vliw_dispatch_checker.sv
module vliw_dispatch_checker #(
    parameter int unsigned N       = 8,
    parameter int unsigned W       = 32,
    parameter int unsigned CHAIN_B = 0
) (
    input logic           clk,
    input logic           rst,
    input logic           fp_valid,
    input logic           fp_ready,
    input logic           fetch_stall,
    input logic [N-1:0]   slot_valid,
    input logic [N*W-1:0] slot_data
);
    logic [N-1:0] low_bit;
    logic [N-1:0] run_sum;

    always_comb begin
        low_bit = slot_valid & (~slot_valid + 1'b1);
        run_sum = slot_valid + low_bit;
    end

    p_stall_blocks_fetch_r8: assert property (@(posedge clk) disable iff (rst)
        fetch_stall |-> !fp_ready);

    p_idle_no_stall_r7: assert property (@(posedge clk) disable iff (rst)
        (slot_valid == '0) |-> !fetch_stall);

    p_stall_then_issue_r6: assert property (@(posedge clk) disable iff (rst)
        fetch_stall |=> (slot_valid != '0));

    p_contiguous_group_r3: assert property (@(posedge clk) disable iff (rst)
        (run_sum & slot_valid) == '0);

    p_final_empties_r7: assert property (@(posedge clk) disable iff (rst)
        ((slot_valid != '0) && !fetch_stall && !fp_valid) |=> (slot_valid == '0));

    for (genvar i = 0; i < N; i++) begin : g_slot
        p_invalid_zero_r5: assert property (@(posedge clk) disable iff (rst)
            !slot_valid[i] |-> (slot_data[i*W +: W] == '0));
        if (i < N - 1) begin : g_link
            p_chain_link_r3: assert property (@(posedge clk) disable iff (rst)
                (slot_valid[i] && slot_valid[i+1]) |-> slot_data[i*W + CHAIN_B]);
        end
    end
endmodule

bind vliw_ep_dispatch vliw_dispatch_checker #(.N(N), .W(W), .CHAIN_B(vliw_disp_pkg::CHAIN_B)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .fp_valid    (fp_valid),
    .fp_ready    (fp_ready),
    .fetch_stall (fetch_stall),
    .slot_valid  (slot_valid),
    .slot_data   (slot_data)
);

// File: tb/test_vliw_ep_dispatch.sv
module test_vliw_ep_dispatch;
    localparam int N     = 8;
    localparam int W     = 32;
    localparam int NPKT  = 135;
    localparam int LIMIT = 20000;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           fp_valid = 1'b0;
    logic [N*W-1:0] fp_data = '0;
    logic           fp_ready;
    logic           fetch_stall;
    logic [N-1:0]   slot_valid;
    logic [N*W-1:0] slot_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    vliw_ep_dispatch i_vliw_ep_dispatch (
        .clk         (clk),
        .rst         (rst),
        .fp_valid    (fp_valid),
        .fp_data     (fp_data),
        .fp_ready    (fp_ready),
        .fetch_stall (fetch_stall),
        .slot_valid  (slot_valid),
        .slot_data   (slot_data)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] pkt_pat(input int p);
        logic [6:0] q;
        if (p == 0) return 8'h6B;
        if (p <= 6) return 8'hFF;
        q = 7'(p - 7);
        return {^q, q};
    endfunction

    function automatic logic [W-1:0] pkt_word(input int p, input int s);
        logic [7:0] pat;
        pat = pkt_pat(p);
        return {16'(p), 8'(s), 7'h2A, pat[s]};
    endfunction

    function automatic int groups_of(input logic [7:0] pat);
        int z = 0;
        for (int i = 0; i < 7; i++) if (!pat[i]) z++;
        return z + 1;
    endfunction

    initial begin
        bit             mh = 1'b0;
        int             ms = 0;
        logic [W-1:0]   mw [N];
        logic [7:0]     cur_pat = '0;
        int             ep_cnt = 0;
        int             st_cnt = 0;
        int             p = 0;
        int             cyc = 0;

        for (int i = 0; i < N; i++) mw[i] = '0;
        repeat (3) begin
            @(negedge clk);
            check(slot_valid == '0 && !fetch_stall && fp_ready, "R1 reset state",
                  {fetch_stall, fp_ready, slot_valid}, 10'h100);
        end
        rst = 1'b0;

        while ((p < NPKT || mh) && !done) begin
            logic [N-1:0] emask;
            int           e;
            bit           stall_e;
            bit           acc;
            @(negedge clk);
            cyc++;
            emask   = '0;
            e       = 0;
            stall_e = 1'b0;
            if (mh) begin
                e = N - 1;
                for (int i = N - 1; i >= ms; i--) if (i == N - 1 || !mw[i][0]) e = i;
                for (int i = ms; i <= e; i++) emask[i] = 1'b1;
                stall_e = (e != N - 1);
            end
            check(slot_valid == emask, (emask[7] && mw[7][0] == 1'b0 && ms <= 6) ? "R4 slot7 flag" : "R3 group mask",
                  slot_valid, emask);
            if (emask[7]) check(slot_valid == emask, "R4 top slot closes group", slot_valid, emask);
            for (int i = 0; i < N; i++) begin
                logic [W-1:0] ew;
                ew = emask[i] ? mw[i] : '0;
                check(slot_data[i*W +: W] == ew, "R5 slot data", slot_data[i*W +: W], ew);
            end
            check(fetch_stall == stall_e, "R7 stall", fetch_stall, stall_e);
            check(fp_ready == !stall_e, "R8 ready", fp_ready, !stall_e);
            if (!mh) check(fp_ready == 1'b1, "R2 ready when empty", fp_ready, 1);

            if (mh) begin
                ep_cnt++;
                if (fetch_stall) st_cnt++;
                if (!stall_e) begin
                    check(ep_cnt == groups_of(cur_pat), "R6 group count", ep_cnt, groups_of(cur_pat));
                    check(st_cnt == groups_of(cur_pat) - 1, "R7 stall cycles", st_cnt, groups_of(cur_pat) - 1);
                    if (cur_pat[6:0] == 7'h7F)
                        check(st_cnt == 0 && ep_cnt == 1, "R9 all parallel", st_cnt, 0);
                end
            end

            fp_valid = (p < NPKT) && (cyc % 11 != 0);
            for (int s = 0; s < N; s++) fp_data[s*W +: W] = pkt_word(p, s);
            acc = fp_valid && !stall_e;

            @(posedge clk);
            if (mh) begin
                if (stall_e) ms = e + 1;
                else mh = 1'b0;
            end
            if (acc) begin
                mh = 1'b1;
                ms = 0;
                for (int s = 0; s < N; s++) mw[s] = pkt_word(p, s);
                cur_pat = pkt_pat(p);
                ep_cnt = 0;
                st_cnt = 0;
                p++;
            end
        end

        @(negedge clk);
        fp_valid = 1'b0;
        check(slot_valid == '0 && !fetch_stall, "R2 drained", slot_valid, 0);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (LIMIT) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog R6 actual=hang expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule